// File: doc/BRIEF.md
# Instruction Decode Group Former

Each cycle this block looks at a window of already length-decoded, already classified instructions and picks which of them go to the decoders in the next cycle. There are four decoder slots. Slot 0 is the complex decoder and accepts any instruction class. Slots 1 to 3 are simple decoders. The block walks the window from oldest to youngest and gives each instruction the next free slot, so program order is always kept. The walk stops at the first invalid entry, or at a complex-class instruction that would land in a simple slot. That instruction then becomes the oldest entry of the next window.

A compare or test that sets flags, followed at once by a valid conditional jump, may be merged into a single slot. Any slot can perform this merge. Only one merge is allowed per cycle. A merge lets five instructions leave the window in one cycle. Merging is turned off while the mode input selects 64-bit operation.

All outputs are registered. An upstream instruction queue uses the consumed count to advance its window by that many entries. A stall input makes the next registered result empty, so the queue does not advance.

Top module: `dgf_group_former`

## Requirements
- R1: While reset is asserted, every slot-valid bit, every fused bit and the consumed count are zero.
- R2: Class codes are: 0 register op, 1 push/pop, 2 load-op, 3 load-op-store. Slot 0 accepts any class. Slots 1 to 3 accept only classes 0 to 2. A class-3 entry that would fall into slot 1, 2 or 3 ends the group before it.
- R3: Slot indices report the window position of the oldest instruction each slot holds. Valid slots fill from slot 0 upward with no gaps, and their indices strictly increase.
- R4: The consumed count equals the number of window entries absorbed. That is one per valid slot plus one for a fused slot, so it is never more than 4 without fusion and never more than 5.
- R5: An entry with the compare flag, followed directly by a valid entry with the jump flag (of any class), occupies one slot. That slot's fused bit is set and it consumes both entries. This works in every slot, including slot 3.
- R6: At most one slot per cycle is fused. Only the oldest eligible pair is merged, and a later eligible pair is placed as two separate instructions.
- R7: When mode_64 is 1, no slot is fused and each instruction takes its own slot.
- R8: The walk stops at the first entry whose valid bit is 0. No younger entry is placed or counted.
- R9: A compare whose next entry is missing or invalid is issued unfused in its slot. It is not held back.
- R10: Outputs change only at the clock edge after the inputs are sampled. With stall high at an edge, the next outputs show no valid slot and a consumed count of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Suppress this cycle's group |
| mode_64 | input | 1 | 1 selects 64-bit mode, which disables fusion |
| win_vld | input | 5 | Valid bit per window entry, bit 0 oldest |
| win_cls | input | 10 | Two-bit class code per entry, entry k at bits 2k+1:2k |
| win_cmp | input | 5 | Entry is a flag-setting compare/test |
| win_jcc | input | 5 | Entry is a conditional jump |
| slot_vld | output | 4 | Slot holds an instruction, bit 0 is the complex slot |
| slot_idx | output | 12 | Three-bit window index per slot, slot s at bits 3s+2:3s |
| slot_fused | output | 4 | Slot holds a fused compare-and-jump pair |
| consumed | output | 3 | Window entries absorbed, 0 to 5 |

## Verification
The bench uses the default build: a five-entry window and four slots. At that size the input space per cycle is small enough to sweep. With every entry valid, it covers every combination of complex-class placement, compare flags and jump flags, in both modes. A second sweep uses every valid-bit pattern, including holes, against every compare/jump combination. This reaches fusion in each slot, competing pairs, missing partners and early stops. Directed cycles then cover reset, stall, the one-cycle output latency and hand-worked cases for the last-slot pair and the double-pair window.

// File: rtl/dgf_pkg.sv
package dgf_pkg;

  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_REG    = 2'd0,
    CLS_STACK  = 2'd1,
    CLS_LDOP   = 2'd2,
    CLS_LDOPST = 2'd3
  } ins_cls_e;

  // Only read-modify-write to memory needs the complex decoder
  function automatic logic cls_is_complex(input logic [CLS_W-1:0] cls);
    return cls == CLS_LDOPST;
  endfunction

endpackage

// File: rtl/dgf_slot_pick.sv
module dgf_slot_pick #(
  parameter int N_ENT   = 5,
  parameter int IDX_W   = 3,
  parameter int SLOT_ID = 0
) (
  input  logic             fuse_en,
  input  logic             run_i,
  input  logic             fuse_avail_i,
  input  logic [IDX_W-1:0] pos_i,
  input  logic [N_ENT-1:0] ent_vld,
  input  logic [N_ENT-1:0] ent_cplx,
  input  logic [N_ENT-1:0] ent_cmp,
  input  logic [N_ENT-1:0] ent_jcc,
  output logic             run_o,
  output logic             fuse_avail_o,
  output logic [IDX_W-1:0] pos_o,
  output logic             take_o,
  output logic             fuse_o
);

  localparam bit CPLX_OK = (SLOT_ID == 0);

  logic [N_ENT-1:0] nxt_vld_vec, nxt_jcc_vec;
  logic cur_vld, cur_cplx, cur_cmp, nxt_vld, nxt_jcc;
  logic take, fuse;

  // neighbour view: bit k holds entry k+1, top bit reads as absent
  assign nxt_vld_vec = ent_vld >> 1;
  assign nxt_jcc_vec = ent_jcc >> 1;

  always_comb begin
    cur_vld  = 1'b0;
    cur_cplx = 1'b0;
    cur_cmp  = 1'b0;
    nxt_vld  = 1'b0;
    nxt_jcc  = 1'b0;
    for (int k = 0; k < N_ENT; k++) begin
      if (pos_i == IDX_W'(k)) begin
        cur_vld  = ent_vld[k];
        cur_cplx = ent_cplx[k];
        cur_cmp  = ent_cmp[k];
        nxt_vld  = nxt_vld_vec[k];
        nxt_jcc  = nxt_jcc_vec[k];
      end
    end
  end

  assign take = run_i && cur_vld && (CPLX_OK || !cur_cplx);
  assign fuse = take && fuse_en && fuse_avail_i && cur_cmp && nxt_vld && nxt_jcc;

  always_comb begin
    if (fuse)      pos_o = pos_i + IDX_W'(2);
    else if (take) pos_o = pos_i + IDX_W'(1);
    else           pos_o = pos_i;
  end

  assign run_o        = take;
  assign fuse_avail_o = fuse_avail_i && !fuse;
  assign take_o       = take;
  assign fuse_o       = fuse;

endmodule

// File: rtl/dgf_out_reg.sv
module dgf_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/dgf_group_former.sv
module dgf_group_former
  import dgf_pkg::*;
#(
  parameter int NUM_ENTRIES = 5,
  parameter int NUM_SLOTS   = 4,
  localparam int IDX_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         stall,
  input  logic                         mode_64,
  input  logic [NUM_ENTRIES-1:0]       win_vld,
  input  logic [NUM_ENTRIES*CLS_W-1:0] win_cls,
  input  logic [NUM_ENTRIES-1:0]       win_cmp,
  input  logic [NUM_ENTRIES-1:0]       win_jcc,
  output logic [NUM_SLOTS-1:0]         slot_vld,
  output logic [NUM_SLOTS*IDX_W-1:0]   slot_idx,
  output logic [NUM_SLOTS-1:0]         slot_fused,
  output logic [IDX_W-1:0]             consumed
);

  localparam int REG_W = 2 * NUM_SLOTS + NUM_SLOTS * IDX_W + IDX_W;

  logic [NUM_ENTRIES-1:0] ent_cplx;
  logic [NUM_SLOTS:0]     run_c, favail_c;
  logic [IDX_W-1:0]       pos_c [NUM_SLOTS+1];
  logic [NUM_SLOTS-1:0]   take_c, fuse_c;
  logic [NUM_SLOTS*IDX_W-1:0] idx_c;
  logic [REG_W-1:0]       nxt_q, cur_q;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cls
    assign ent_cplx[e] = cls_is_complex(win_cls[e*CLS_W +: CLS_W]);
  end

  assign run_c[0]    = 1'b1;
  assign favail_c[0] = 1'b1;
  assign pos_c[0]    = '0;

  // one picker per slot, chained oldest-first
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    dgf_slot_pick #(
      .N_ENT  (NUM_ENTRIES),
      .IDX_W  (IDX_W),
      .SLOT_ID(s)
    ) u_pick (
      .fuse_en     (!mode_64),
      .run_i       (run_c[s]),
      .fuse_avail_i(favail_c[s]),
      .pos_i       (pos_c[s]),
      .ent_vld     (win_vld),
      .ent_cplx    (ent_cplx),
      .ent_cmp     (win_cmp),
      .ent_jcc     (win_jcc),
      .run_o       (run_c[s+1]),
      .fuse_avail_o(favail_c[s+1]),
      .pos_o       (pos_c[s+1]),
      .take_o      (take_c[s]),
      .fuse_o      (fuse_c[s])
    );
    assign idx_c[s*IDX_W +: IDX_W] = take_c[s] ? pos_c[s] : '0;
  end

  // next-state: a stalled cycle registers an empty group
  always_comb begin
    if (stall) nxt_q = '0;
    else       nxt_q = {take_c, fuse_c, idx_c, pos_c[NUM_SLOTS]};
  end

  dgf_out_reg #(.W(REG_W)) u_oreg (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (1'b1),
    .d    (nxt_q),
    .q    (cur_q)
  );

  assign {slot_vld, slot_fused, slot_idx, consumed} = cur_q;

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consumed <= IDX_W'(NUM_ENTRIES));

  // R4
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(consumed) == $countones(slot_vld) + $countones(slot_fused));

  // R6
  one_fuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_fused) <= 1);

  // R5
  fused_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_fused & ~slot_vld) == '0);

  // R7
  no_fuse_64_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_64) |-> slot_fused == '0);

  // R10
  stall_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stall) |-> (consumed == '0 && slot_vld == '0));

  for (genvar s = 1; s < NUM_SLOTS; s++) begin : g_ord_chk
    // R3
    slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_vld[s] |-> (slot_vld[s-1] &&
        slot_idx[s*IDX_W +: IDX_W] > slot_idx[(s-1)*IDX_W +: IDX_W]));
  end

endmodule

// File: tb/dgf_group_former_bench.sv
`timescale 1ns/1ps
module dgf_group_former_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall, mode_64;
  logic [4:0]  win_vld, win_cmp, win_jcc;
  logic [9:0]  win_cls;
  logic [3:0]  slot_vld, slot_fused;
  logic [11:0] slot_idx;
  logic [2:0]  consumed;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  dgf_group_former u_dgf_group_former (
    .clk(clk), .rst_n(rst_n), .stall(stall), .mode_64(mode_64),
    .win_vld(win_vld), .win_cls(win_cls), .win_cmp(win_cmp), .win_jcc(win_jcc),
    .slot_vld(slot_vld), .slot_idx(slot_idx), .slot_fused(slot_fused),
    .consumed(consumed)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected group from the requirements: oldest-first walk over four slots
  function automatic void model(input logic [4:0] v, input logic [4:0] cx,
                                input logic [4:0] cm, input logic [4:0] jc,
                                input logic m64,
                                output logic [3:0] ev, output logic [11:0] ei,
                                output logic [3:0] ef, output logic [2:0] en);
    int p = 0;
    bit used = 1'b0;
    bit stop = 1'b0;
    ev = '0; ei = '0; ef = '0;
    for (int s = 0; s < 4; s++) begin
      if (!stop) begin
        if (p >= 5) stop = 1'b1;
        else if (!v[p]) stop = 1'b1;
        else if (cx[p] && s != 0) stop = 1'b1;
        else begin
          ev[s] = 1'b1;
          ei[s*3 +: 3] = 3'(p);
          if (!m64 && !used && cm[p] && p < 4 && v[(p+1)%5] && jc[(p+1)%5]) begin
            ef[s] = 1'b1; used = 1'b1; p = p + 2;
          end else p = p + 1;
        end
      end
    end
    en = 3'(p);
  endfunction

  function automatic logic [9:0] mk_cls(input logic [4:0] cx, input int seed);
    logic [9:0] r;
    for (int k = 0; k < 5; k++)
      r[2*k +: 2] = cx[k] ? 2'd3 : 2'((k + seed) % 3);
    return r;
  endfunction

  logic [3:0]  x_v, x_f;
  logic [11:0] x_i;
  logic [2:0]  x_n;
  bit have = 1'b0;

  task automatic cmp_prev();
    if (have) begin
      chk("R2 slot_vld", 16'(slot_vld), 16'(x_v));
      chk("R3 slot_idx", 16'(slot_idx), 16'(x_i));
      chk("R5 slot_fused", 16'(slot_fused), 16'(x_f));
      chk("R4 consumed", 16'(consumed), 16'(x_n));
    end
  endtask

  // pipelined: check previous vector, then drive the next one
  task automatic step(input logic [4:0] v, input logic [4:0] cx,
                      input logic [4:0] cm, input logic [4:0] jc,
                      input logic m64, input int seed);
    @(negedge clk);
    cmp_prev();
    win_vld = v; win_cls = mk_cls(cx, seed); win_cmp = cm; win_jcc = jc;
    mode_64 = m64;
    model(v, cx, cm, jc, m64, x_v, x_i, x_f, x_n);
    have = 1'b1;
  endtask

  task automatic flush();
    @(negedge clk);
    cmp_prev();
    have = 1'b0;
  endtask

  // directed vector with hand-worked expectations
  task automatic dir(input string tag, input logic [4:0] v, input logic [4:0] cx,
                     input logic [4:0] cm, input logic [4:0] jc, input logic m64,
                     input logic [3:0] ev, input logic [11:0] ei,
                     input logic [3:0] ef, input logic [2:0] en);
    @(negedge clk);
    win_vld = v; win_cls = mk_cls(cx, 0); win_cmp = cm; win_jcc = jc; mode_64 = m64;
    @(negedge clk);
    chk(tag, 16'(slot_vld), 16'(ev));
    chk(tag, 16'(slot_idx), 16'(ei));
    chk(tag, 16'(slot_fused), 16'(ef));
    chk(tag, 16'(consumed), 16'(en));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stall = 1'b0; mode_64 = 1'b0;
    win_vld = 5'h1f; win_cls = '0; win_cmp = 5'h01; win_jcc = 5'h02;
    repeat (3) @(negedge clk);
    // R1: reset holds all outputs at zero despite a full window
    chk("R1 slot_vld", 16'(slot_vld), 16'h0);
    chk("R1 slot_fused", 16'(slot_fused), 16'h0);
    chk("R1 consumed", 16'(consumed), 16'h0);
    rst_n = 1'b1;

    // R8: hole at entry 2 stops the walk after two entries
    dir("R8", 5'b11011, 5'h00, 5'h00, 5'h00, 1'b0, 4'b0011, {3'd0,3'd0,3'd1,3'd0}, 4'b0000, 3'd2);
    // R9: compare in slot 3 with an invalid partner issues alone
    dir("R9", 5'b01111, 5'h00, 5'b01000, 5'b10000, 1'b0, 4'b1111, {3'd3,3'd2,3'd1,3'd0}, 4'b0000, 3'd4);
    // R5: pair in the last slot gives five consumed
    dir("R5", 5'b11111, 5'h00, 5'b01000, 5'b10000, 1'b0, 4'b1111, {3'd3,3'd2,3'd1,3'd0}, 4'b1000, 3'd5);
    // R6: two eligible pairs, only the oldest merges
    dir("R6", 5'b11111, 5'h00, 5'b00101, 5'b01010, 1'b0, 4'b1111, {3'd4,3'd3,3'd2,3'd0}, 4'b0001, 3'd5);
    // R7: same window in 64-bit mode, no merge, four consumed
    dir("R7", 5'b11111, 5'h00, 5'b00101, 5'b01010, 1'b1, 4'b1111, {3'd3,3'd2,3'd1,3'd0}, 4'b0000, 3'd4);
    // R2: load-op-store at entry 2 ends the group at two
    dir("R2", 5'b11111, 5'b00100, 5'h00, 5'h00, 1'b0, 4'b0011, {3'd0,3'd0,3'd1,3'd0}, 4'b0000, 3'd2);
    // R2: load-op-store at entry 0 takes the complex slot
    dir("R2", 5'b11111, 5'b00001, 5'h00, 5'h00, 1'b0, 4'b1111, {3'd3,3'd2,3'd1,3'd0}, 4'b0000, 3'd4);

    // R10: stall empties the next result
    @(negedge clk);
    stall = 1'b1; win_vld = 5'h1f; win_cls = '0; win_cmp = '0; win_jcc = '0; mode_64 = 1'b0;
    @(negedge clk);
    chk("R10 stall vld", 16'(slot_vld), 16'h0);
    chk("R10 stall consumed", 16'(consumed), 16'h0);
    stall = 1'b0;
    #1;
    chk("R10 latency", 16'(consumed), 16'h0);
    @(negedge clk);
    chk("R10 after edge", 16'(consumed), 16'd4);

    // full window: every complex/compare/jump pattern in both modes
    for (int m = 0; m < 2; m++)
      for (int cx = 0; cx < 32; cx++)
        for (int cm = 0; cm < 32; cm++)
          for (int jc = 0; jc < 32; jc++)
            step(5'h1f, 5'(cx), 5'(cm), 5'(jc), 1'(m), cm + jc);
    // every valid pattern with compare/jump patterns, all simple
    for (int v = 0; v < 32; v++)
      for (int cm = 0; cm < 32; cm++)
        for (int jc = 0; jc < 32; jc++)
          step(5'(v), 5'h00, 5'(cm), 5'(jc), 1'b0, v + jc);
    flush();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule